// File: doc/BRIEF.md
# Fixed-Priority Five-Source Interrupt Controller

This block sits beside a small CPU core. It chooses which of five interrupt sources the core services next. Two of the sources are active-low external pins. The other three are flags raised by peripherals: two timer overflow flags and one combined serial transmit/receive flag. A configuration register gates each source. It holds one enable bit per source and a master enable bit that overrides all of them. A second register sets each external pin to be sensed either by its low level or by a falling edge.

When at least one gated source is active and no handler is running, the block raises a request to the core. With the request it presents the vector address of the winning source, chosen in a fixed order. The core accepts with an acknowledge strobe. From that point the block holds an in-service state and presents no further request until the core signals return-from-interrupt. On acknowledge, the block clears the latched edge flag of an external pin and pulses a clear to the winning timer. The serial flag is left untouched, so its handler must clear it.

Top module: `irq_arbiter_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq_req` and `in_service` are low, and `pend_o` is 0 while all pins are high and all flags are low.
- R2: Writing with `cfg_sel`=0 loads the enable register. Bit 7 is the master enable, bit 4 is serial, bit 3 is timer 1, bit 2 is external 1, bit 1 is timer 0 and bit 0 is external 0. Bits 6 and 5 always read 0. Writing with `cfg_sel`=1 loads the sense bits from `cfg_wdata[1:0]`, where bit k=1 selects edge mode for external pin k.
- R3: A source produces a request only when both bit 7 and its own enable bit are set.
- R4: Among several gated sources, the winner is external 0, then timer 0, then external 1, then timer 1, then serial.
- R5: `irq_vec` is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial.
- R6: In level mode a pin requests only while it is low. Nothing is latched, so a pin that returns high before acknowledge leaves no request.
- R7: In edge mode a falling edge sets a pending flag (`pend_o` bit 0 for pin 0, bit 2 for pin 1). The flag stays set after the pin returns high and clears when that source is acknowledged.
- R8: `irq_ack` while `irq_req` is high enters the in-service state. While in service, `irq_req` stays low. `reti` leaves the state, and any request still pending is then presented.
- R9: A level-mode pin still low at `reti` requests again. An edge-mode pin still low after its acknowledge does not.
- R10: Acknowledging timer k pulses `tmr_clr[k]` in the acknowledge cycle. Acknowledging serial pulses no clear, and a serial flag still high requests again after `reti`.
- R11: `irq_ack` while `irq_req` is low is ignored and leaves `in_service` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the sense bits |
| cfg_wdata | input | 8 | Write data |
| en_mask_o | output | 8 | Current enable register |
| sense_o | output | 2 | Current sense bits (1 means edge mode) |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow flags |
| ser_flag | input | 1 | Serial transmit/receive flag |
| pend_o | output | 5 | Raw per-source requests before gating, in priority order |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | ADDR_W | Vector address of the winner |
| irq_ack | input | 1 | Core accepts the request |
| reti | input | 1 | Return-from-interrupt strobe |
| in_service | output | 1 | Handler running |
| tmr_clr | output | 2 | One-cycle clear to the timer flags |

## Verification
The bench builds the block with its default parameters: a 16-bit vector, base 0x0003, step 8 and a two-flop pin synchronizer. Under these values every vector address lies in the low table, and a pin change reaches the request within three clocks. This lets directed sequences cover both level and edge behaviour within a handful of cycles. Random mixes of enable values, pin levels and flags then exercise the priority walk, and the vector model is written as a lookup table in the bench rather than arithmetic.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC       = 5;
  localparam int IDX_W      = 3;
  localparam int GLOBAL_BIT = 7;

  // Source index equals priority rank (0 = highest).
  typedef enum logic [IDX_W-1:0] {
    SRC_EX0 = 3'd0,
    SRC_TM0 = 3'd1,
    SRC_EX1 = 3'd2,
    SRC_TM1 = 3'd3,
    SRC_SER = 3'd4
  } src_e;

  // Vector address of a source: base plus a fixed stride per rank.
  function automatic int vec_of(input logic [IDX_W-1:0] idx, input int base, input int step);
    return base + int'(idx) * step;
  endfunction

  // Mask of the enable register bits that are implemented.
  function automatic logic [7:0] en_write_mask();
    return 8'b1001_1111;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] en_q,
  output logic [1:0] sense_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
    end else if (wr) begin
      if (sel) sense_q <= wdata[1:0];
      else     en_q    <= wdata & irq_pkg::en_write_mask();
    end
  end
endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   cur;
  logic                   fell;

  assign cur  = sync_q[SYNC_STAGES-1];
  assign fell = prev_q & ~cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= cur;
      // A new edge wins over a clear in the same cycle.
      flag_q <= edge_mode & (fell | (flag_q & ~clr));
    end
  end

  assign req = edge_mode ? flag_q : ~cur;
endmodule

// File: rtl/irq_fixed_pick.sv
module irq_fixed_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     gated,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gated[i]) idx = IDX_W'(i);
    end
  end
  assign any = |gated;
endmodule

// File: rtl/irq_arbiter_ctrl.sv
module irq_arbiter_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        en_mask_o,
  output logic [1:0]        sense_o,
  input  logic [1:0]        ext_pin_n,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_flag,
  output logic [4:0]        pend_o,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_vec,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              in_service,
  output logic [1:0]        tmr_clr
);
  import irq_pkg::*;

  logic [7:0]       en_q;
  logic [1:0]       sense_q;
  logic [1:0]       ext_req;
  logic [1:0]       ext_clr;
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  gated;
  logic             any_req;
  logic [IDX_W-1:0] win;
  logic             take;
  logic             svc_q;

  irq_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .en_q(en_q), .sense_q(sense_q)
  );

  for (genvar k = 0; k < 2; k++) begin : g_pin
    irq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[k]),
      .edge_mode(sense_q[k]), .clr(ext_clr[k]), .req(ext_req[k])
    );
  end

  assign raw   = {ser_flag, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
  assign gated = raw & en_q[NSRC-1:0] & {NSRC{en_q[GLOBAL_BIT]}};

  irq_fixed_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .gated(gated), .any(any_req), .idx(win)
  );

  assign irq_req = any_req & ~svc_q;
  assign take    = irq_req & irq_ack;

  assign ext_clr[0] = take & (win == SRC_EX0);
  assign ext_clr[1] = take & (win == SRC_EX1);
  assign tmr_clr[0] = take & (win == SRC_TM0);
  assign tmr_clr[1] = take & (win == SRC_TM1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    svc_q <= 1'b0;
    else if (take) svc_q <= 1'b1;
    else if (reti) svc_q <= 1'b0;
  end

  assign irq_vec    = ADDR_W'(vec_of(win, VEC_BASE, VEC_STEP));
  assign in_service = svc_q;
  assign en_mask_o  = en_q;
  assign sense_o    = sense_q;
  assign pend_o     = raw;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        en_mask_o,
  input logic              irq_req,
  input logic [ADDR_W-1:0] irq_vec,
  input logic              irq_ack,
  input logic              reti,
  input logic              in_service,
  input logic [1:0]        tmr_clr
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_mask_o[6:5] == 2'b00);
  p_needs_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_mask_o[7]);
  p_vec_in_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= ADDR_W'(16'h0023)));
  p_quiet_in_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !irq_req);
  p_ack_enters_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> in_service);
  p_reti_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && reti) |=> !in_service);
  p_tmr_clr_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr != 2'b00) |-> (irq_ack && irq_req && $onehot0(tmr_clr)));
  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !in_service && irq_ack) |=> !in_service);
endmodule

bind irq_arbiter_ctrl irq_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_mask_o(en_mask_o), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti),
  .in_service(in_service), .tmr_clr(tmr_clr)
);

// File: tb/irq_arbiter_ctrl_tb.sv
module irq_arbiter_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  en_mask_o;
  logic [1:0]  sense_o;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_flag = 1'b0;
  logic [4:0]  pend_o;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0, reti = 1'b0;
  logic        in_service;
  logic [1:0]  tmr_clr;
  logic [1:0]  clr_seen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    @(posedge clk); #1;
    irq_ack = 1'b1;
    @(negedge clk);
    clr_seen = tmr_clr;
    @(posedge clk); #1;
    irq_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reti();
    @(posedge clk); #1;
    reti = 1'b1;
    @(posedge clk); #1;
    reti = 1'b0;
    @(negedge clk);
  endtask

  // Bench model: vector table as lookup, winner by explicit walk.
  function automatic logic [15:0] tbl_vec(input int i);
    case (i)
      0: return 16'h0003;
      1: return 16'h000B;
      2: return 16'h0013;
      3: return 16'h001B;
      default: return 16'h0023;
    endcase
  endfunction

  function automatic int model_win(input logic [7:0] en, input logic [4:0] srcs);
    logic [4:0] g;
    if (!en[7]) return -1;
    g = srcs & en[4:0];
    for (int i = 0; i < 5; i++) if (g[i]) return i;
    return -1;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    chk("R1 enable", en_mask_o, 8'h00);
    chk("R1 req", irq_req, 1'b0);
    chk("R1 svc", in_service, 1'b0);
    chk("R1 pend", pend_o, 5'h00);

    // R2 register layout, reserved bits
    cfg(1'b0, 8'hFF);
    chk("R2 reserved read zero", en_mask_o, 8'h9F);
    cfg(1'b1, 8'hFE);
    chk("R2 sense bits", sense_o, 2'b10);
    cfg(1'b1, 8'h00);

    // R3 master gate
    tmr_ovf[0] = 1'b1;
    cfg(1'b0, 8'h1F);
    chk("R3 no master", irq_req, 1'b0);
    cfg(1'b0, 8'h80);
    chk("R3 no individual", irq_req, 1'b0);
    cfg(1'b0, 8'h82);
    chk("R3 both set", irq_req, 1'b1);
    chk("R5 timer0 vec", irq_vec, 16'h000B);

    // R4/R5 priority walk, all sources active in level mode
    ext_pin_n = 2'b00; tmr_ovf = 2'b11; ser_flag = 1'b1;
    settle(3);
    for (int b = 0; b < 5; b++) begin
      cfg(1'b0, 8'h80 | (8'h1F & ~((8'h1 << b) - 8'h1)));
      chk("R4 priority walk", irq_req, 1'b1);
      chk("R5 vector by rank", irq_vec, tbl_vec(b));
    end
    ext_pin_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b0;

    // R6 level not latched
    cfg(1'b0, 8'h81);
    @(posedge clk); #1; ext_pin_n[0] = 1'b0;
    settle(3);
    chk("R6 level low requests", irq_req, 1'b1);
    @(posedge clk); #1; ext_pin_n[0] = 1'b1;
    settle(3);
    chk("R6 released no request", irq_req, 1'b0);

    // R7 edge latch and clear on ack
    cfg(1'b1, 8'h01);
    @(posedge clk); #1; ext_pin_n[0] = 1'b0;
    settle(2);
    @(posedge clk); #1; ext_pin_n[0] = 1'b1;
    settle(4);
    chk("R7 flag held after release", pend_o[0], 1'b1);
    chk("R7 edge request", irq_req, 1'b1);
    ack();
    chk("R7 flag cleared by ack", pend_o[0], 1'b0);
    chk("R8 enters service", in_service, 1'b1);

    // R8 held while in service
    cfg(1'b0, 8'h83);
    tmr_ovf[0] = 1'b1;
    settle(2);
    chk("R8 no request in service", irq_req, 1'b0);
    do_reti();
    chk("R8 pending presented after reti", irq_req, 1'b1);
    chk("R8 pending vector", irq_vec, 16'h000B);
    ack();
    chk("R10 timer0 clear pulse", clr_seen, 2'b01);
    tmr_ovf[0] = 1'b0;
    do_reti();

    // R9 level re-fire vs edge
    cfg(1'b1, 8'h00);
    cfg(1'b0, 8'h84);
    @(posedge clk); #1; ext_pin_n[1] = 1'b0;
    settle(3);
    ack();
    chk("R9 ext1 no timer clear", clr_seen, 2'b00);
    do_reti();
    chk("R9 level refire", irq_req, 1'b1);
    chk("R9 level refire vec", irq_vec, 16'h0013);
    @(posedge clk); #1; ext_pin_n[1] = 1'b1;
    cfg(1'b1, 8'h02);
    @(posedge clk); #1; ext_pin_n[1] = 1'b0;
    settle(4);
    chk("R9 edge request", irq_req, 1'b1);
    ack();
    do_reti();
    settle(2);
    chk("R9 edge no refire", irq_req, 1'b0);
    ext_pin_n = 2'b11;
    cfg(1'b1, 8'h00);
    settle(3);

    // R10 serial not cleared
    cfg(1'b0, 8'h90);
    ser_flag = 1'b1;
    settle(1);
    chk("R10 serial vec", irq_vec, 16'h0023);
    ack();
    chk("R10 serial no clear", clr_seen, 2'b00);
    do_reti();
    chk("R10 serial requests again", irq_req, 1'b1);
    ser_flag = 1'b0;

    // R11 stray ack
    cfg(1'b0, 8'h00);
    ack();
    chk("R11 stray ack ignored", in_service, 1'b0);

    // Random mixes, level mode
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 60; it++) begin
      logic [7:0] en;
      logic [4:0] srcs;
      int w;
      en = 8'($urandom()) & 8'h9F;
      if (it % 3 != 0) en[7] = 1'b1;
      cfg(1'b0, en);
      @(posedge clk); #1;
      ext_pin_n = 2'($urandom());
      tmr_ovf   = 2'($urandom());
      ser_flag  = 1'($urandom());
      settle(3);
      srcs = {ser_flag, tmr_ovf[1], ~ext_pin_n[1], tmr_ovf[0], ~ext_pin_n[0]};
      w = model_win(en, srcs);
      chk("R4 random req", irq_req, (w >= 0));
      if (w >= 0) begin
        chk("R5 random vec", irq_vec, tbl_vec(w));
        ack();
        chk("R10 random clear", clr_seen,
            (w == 1) ? 2'b01 : (w == 3) ? 2'b10 : 2'b00);
        do_reti();
      end
    end
    ext_pin_n = 2'b11; tmr_ovf = '0; ser_flag = 1'b0;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule